// File: doc/BRIEF.md
# Frame-Synced Serial Pin Multiplexer

This block moves a parallel word of pin states across a two-wire serial link, one frame at a time, and collects a received word of the same length in return. It derives a bit clock from the system clock with a programmable scale factor. When a frame is started, it marks the frame with a sync pulse one bit period wide, then shifts the transmit word out most-significant bit first while sampling the receive line into a shift register.

The bit clock pin has three flavours. In the time-division mode it toggles continuously. In the SPI-style mode it is gated so that it only pulses during the data bits and rests low between frames. The inverted SPI-style mode rests high and pulses low. Once a frame has started, further start requests are dropped until that frame has ended.

Top module: `fsp_serial_mux`

## Requirements
- R1: The internal bit clock has a period of 2·max(N,1) system clocks, where N is `scale_i`, so N = 0 behaves exactly as N = 1. `tclk_o` in the time-division mode shows that clock high for the first half of each period.
- R2: A frame begins when the sync output rises on the same system-clock edge as a rising edge of the bit clock. Sync then stays high for exactly one bit period (2·max(N,1) system clocks).
- R3: `tx_o` is high for the whole time sync is high, and low whenever no frame is in progress.
- R4: On the falling edge of sync, `tx_o` starts to present the transmit word captured at the sync rising edge, most-significant bit first, one bit per bit period. Later changes on `tx_word_i` do not affect that frame.
- R5: The receive line is sampled once per data bit, at the falling edge of the internal bit clock (mid-bit). The 16 samples are assembled most-significant bit first and appear on `rx_word_o` when the last one is taken.
- R6: A frame carries exactly 16 data bits, and sync stays low throughout them. The frame ends one half bit period after the last sample, and `tx_o` returns low at that point.
- R7: `done_o` is high for exactly one system clock, 33·max(N,1) system clocks after sync rises. That is the clock in which the 16th bit is captured.
- R8: `clk_mode_i` bit 0 selects the SPI-style gating and bit 1 inverts the resting level (it takes effect in SPI-style mode only). In SPI-style mode `tclk_o` rests at the idle level outside the 16 data bits, and equals the bit clock XOR the idle level during them.
- R9: A start request made while a frame is in progress, including its final half bit, is ignored. No second frame follows unless a fresh start is given after the frame ends.
- R10: After reset, sync, `tx_o`, `done_o` and `rx_word_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| scale_i | input | 8 | Clock scale N; bit clock = system clock / (2·max(N,1)) |
| clk_mode_i | input | 2 | Bit 0: SPI-style gating; bit 1: inverted resting level in SPI-style mode |
| start_i | input | 1 | Request one frame; ignored while a frame is in progress |
| tx_word_i | input | 16 | Parallel word to transmit |
| rx_i | input | 1 | Serial receive line |
| sync_o | output | 1 | Frame sync pulse |
| tclk_o | output | 1 | Bit clock pin |
| tx_o | output | 1 | Serial transmit line |
| rx_word_o | output | 16 | Last complete received word |
| done_o | output | 1 | One-clock pulse when the 16th bit is captured |

## Verification
The embedded assertions assume that `scale_i` and `clk_mode_i` change only while no frame is running. They also assume that `rx_i` is settled at each mid-bit sample point. The stimulus sets the scale and mode only before it issues a start. It drives `rx_i` from `tx_o`, either directly or inverted, so that the received bit is stable through each whole bit period. Start requests inside a running frame are deliberately issued to exercise the ignore rule, and the assertions hold under that stimulus as well.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE  = 3'd0,
    SEQ_ARMED = 3'd1,
    SEQ_SYNC  = 3'd2,
    SEQ_DATA  = 3'd3,
    SEQ_TRAIL = 3'd4
  } seq_state_t;

  // Half bit-clock period in system clocks; zero scale behaves as one.
  function automatic int unsigned half_period(input int unsigned scale);
    return (scale == 0) ? 1 : scale;
  endfunction

  // Level driven on the bit clock pin.
  function automatic logic pin_level(input logic phase, input logic win,
                                     input logic [1:0] mode);
    logic idle_lvl;
    idle_lvl = mode[0] & mode[1];
    if (!mode[0]) return phase;
    return win ? (phase ^ idle_lvl) : idle_lvl;
  endfunction

endpackage

// File: rtl/fsp_bitclk_div.sv
module fsp_bitclk_div #(
  parameter int SCALE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SCALE_W-1:0] scale_i,
  output logic               phase_o,
  output logic               rise_ev_o,
  output logic               fall_ev_o
);
  import fsp_pkg::*;

  localparam int CNT_W = SCALE_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;
  logic             tick;

  always_comb begin
    last_cnt = CNT_W'(half_period(int'(scale_i)) - 1);
    tick     = (cnt_q >= last_cnt);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_o <= 1'b0;
    end else begin
      cnt_q   <= tick ? '0 : cnt_q + 1'b1;
      phase_o <= phase_o ^ tick;
    end
  end

  assign rise_ev_o = tick & ~phase_o;
  assign fall_ev_o = tick &  phase_o;

  // A stable scale keeps the counter inside its half period (R1).
  assert_cnt_in_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(scale_i) && $past($stable(scale_i)) |-> cnt_q <= last_cnt);

endmodule

// File: rtl/fsp_frame_seq.sv
module fsp_frame_seq #(
  parameter int FRAME_BITS = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [FRAME_BITS-1:0] tx_word_i,
  input  logic                  rise_ev_i,
  input  logic                  fall_ev_i,
  input  logic                  rx_i,
  output logic                  sync_o,
  output logic                  tx_o,
  output logic [FRAME_BITS-1:0] rx_word_o,
  output logic                  done_o,
  output logic                  data_win_o,
  output logic                  busy_o
);
  import fsp_pkg::*;

  localparam int BCNT_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(FRAME_BITS - 1);

  seq_state_t            state_q;
  logic [FRAME_BITS-1:0] tx_sh_q;
  logic [FRAME_BITS-1:0] rx_sh_q;
  logic [BCNT_W-1:0]     bit_q;
  logic [FRAME_BITS-1:0] rx_next;

  assign rx_next = {rx_sh_q[FRAME_BITS-2:0], rx_i};

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q   <= SEQ_IDLE;
      tx_sh_q   <= '0;
      rx_sh_q   <= '0;
      bit_q     <= '0;
      sync_o    <= 1'b0;
      tx_o      <= 1'b0;
      rx_word_o <= '0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: begin
          if (start_i) state_q <= SEQ_ARMED;
        end
        SEQ_ARMED: begin
          if (rise_ev_i) begin
            state_q <= SEQ_SYNC;
            sync_o  <= 1'b1;
            tx_o    <= 1'b1;
            tx_sh_q <= tx_word_i;
          end
        end
        SEQ_SYNC: begin
          if (rise_ev_i) begin
            state_q <= SEQ_DATA;
            sync_o  <= 1'b0;
            tx_o    <= tx_sh_q[FRAME_BITS-1];
            tx_sh_q <= tx_sh_q << 1;
            bit_q   <= '0;
          end
        end
        SEQ_DATA: begin
          if (rise_ev_i) begin
            tx_o    <= tx_sh_q[FRAME_BITS-1];
            tx_sh_q <= tx_sh_q << 1;
          end
          if (fall_ev_i) begin
            rx_sh_q <= rx_next;
            if (bit_q == LAST_BIT) begin
              state_q   <= SEQ_TRAIL;
              rx_word_o <= rx_next;
              done_o    <= 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        SEQ_TRAIL: begin
          if (rise_ev_i) begin
            state_q <= SEQ_IDLE;
            tx_o    <= 1'b0;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign data_win_o = (state_q == SEQ_DATA) || (state_q == SEQ_TRAIL);
  assign busy_o     = (state_q != SEQ_IDLE);

  assert_tx_high_in_sync_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> tx_o);

  assert_sync_on_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> $past(rise_ev_i));

  assert_sync_low_in_data_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_win_o |-> !sync_o);

  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_on_sample_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(fall_ev_i));

  assert_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_DATA) && start_i |=> state_q != SEQ_ARMED);

endmodule

// File: rtl/fsp_clk_pin.sv
module fsp_clk_pin (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       phase_i,
  input  logic       data_win_i,
  input  logic [1:0] mode_i,
  output logic       tclk_o
);
  import fsp_pkg::*;

  logic idle_lvl;

  assign idle_lvl = mode_i[0] & mode_i[1];
  assign tclk_o   = pin_level(phase_i, data_win_i, mode_i);

  assert_spi_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[0] && !data_win_i |-> tclk_o == idle_lvl);

  assert_tdm_free_run_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i[0] |-> tclk_o == phase_i);

endmodule

// File: rtl/fsp_serial_mux.sv
module fsp_serial_mux #(
  parameter int SCALE_W    = 8,
  parameter int FRAME_BITS = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [SCALE_W-1:0]    scale_i,
  input  logic [1:0]            clk_mode_i,
  input  logic                  start_i,
  input  logic [FRAME_BITS-1:0] tx_word_i,
  input  logic                  rx_i,
  output logic                  sync_o,
  output logic                  tclk_o,
  output logic                  tx_o,
  output logic [FRAME_BITS-1:0] rx_word_o,
  output logic                  done_o
);

  logic phase;
  logic rise_ev;
  logic fall_ev;
  logic data_win;
  logic busy;

  fsp_bitclk_div #(.SCALE_W(SCALE_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scale_i   (scale_i),
    .phase_o   (phase),
    .rise_ev_o (rise_ev),
    .fall_ev_o (fall_ev)
  );

  fsp_frame_seq #(.FRAME_BITS(FRAME_BITS)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .tx_word_i  (tx_word_i),
    .rise_ev_i  (rise_ev),
    .fall_ev_i  (fall_ev),
    .rx_i       (rx_i),
    .sync_o     (sync_o),
    .tx_o       (tx_o),
    .rx_word_o  (rx_word_o),
    .done_o     (done_o),
    .data_win_o (data_win),
    .busy_o     (busy)
  );

  fsp_clk_pin u_pin (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .phase_i    (phase),
    .data_win_i (data_win),
    .mode_i     (clk_mode_i),
    .tclk_o     (tclk_o)
  );

  // Outside a frame the transmit line rests low (R3).
  assert_tx_low_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !tx_o);

endmodule

// File: tb/fsp_serial_mux_test.sv
module fsp_serial_mux_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  scale = 8'd1;
  logic [1:0]  mode = 2'b00;
  logic        start = 1'b0;
  logic [15:0] tx_word = 16'h0;
  logic        rx_invert = 1'b0;
  logic        rx_pin;
  logic        sync_w, tclk_w, tx_w, done_w;
  logic [15:0] rx_word_w;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  assign rx_pin = rx_invert ? ~tx_w : tx_w;

  fsp_serial_mux uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scale_i    (scale),
    .clk_mode_i (mode),
    .start_i    (start),
    .tx_word_i  (tx_word),
    .rx_i       (rx_pin),
    .sync_o     (sync_w),
    .tclk_o     (tclk_w),
    .tx_o       (tx_w),
    .rx_word_o  (rx_word_w),
    .done_o     (done_w)
  );

  task automatic check(input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic run_frame(input int n, input logic [1:0] m,
                           input logic [15:0] word, input logic rinv);
    int hp, per, found;
    logic spi, idle_lvl, raw, exp_pin, exp_tx;
    logic [15:0] exp_rx;
    hp = (n == 0) ? 1 : n;
    per = 2 * hp;
    spi = m[0];
    idle_lvl = m[0] & m[1];
    exp_rx = rinv ? ~word : word;
    @(negedge clk);
    scale = n[7:0];
    mode = m;
    tx_word = word;
    rx_invert = rinv;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    found = 0;
    for (int w = 0; w < 200 && found == 0; w++) begin
      if (sync_w) found = 1;
      else @(negedge clk);
    end
    if (found == 0) check("R2 sync never rose", 16'd0, 16'd1);
    for (int t = 0; t <= 34 * hp; t++) begin
      if (t > 0) @(negedge clk);
      if (t == 1) tx_word = ~word;          // R4: late change ignored
      if (t == 10) start = 1'b1;            // R9: request inside a frame
      if (t == 11) start = 1'b0;
      raw = ((t % per) < hp);
      if (!spi) exp_pin = raw;
      else if (t >= per && t < 34 * hp) exp_pin = raw ^ idle_lvl;
      else exp_pin = idle_lvl;
      if (t < per) exp_tx = 1'b1;
      else if (t < 34 * hp) exp_tx = word[15 - (t / per - 1)];
      else exp_tx = 1'b0;
      check("R2/R6 sync", {15'd0, sync_w}, {15'd0, (t < per)});
      check("R3/R4 tx", {15'd0, tx_w}, {15'd0, exp_tx});
      check("R1/R8 tclk", {15'd0, tclk_w}, {15'd0, exp_pin});
      check("R7 done", {15'd0, done_w}, {15'd0, (t == 33 * hp)});
      if (t == 34 * hp) check("R5 rx_word", rx_word_w, exp_rx);
    end
    // R9: the in-frame start must not produce another frame; R8 idle level.
    for (int k = 0; k < 4 * hp + 6; k++) begin
      @(negedge clk);
      check("R9 no extra sync", {15'd0, sync_w}, 16'd0);
      check("R3 tx idle", {15'd0, tx_w}, 16'd0);
      if (spi) check("R8 idle clock", {15'd0, tclk_w}, {15'd0, idle_lvl});
    end
  endtask

  initial begin
    #(200000 * 5);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [15:0] pat;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check("R10 sync", {15'd0, sync_w}, 16'd0);
    check("R10 tx", {15'd0, tx_w}, 16'd0);
    check("R10 done", {15'd0, done_w}, 16'd0);
    check("R10 rx_word", rx_word_w, 16'd0);
    for (int m = 0; m < 4; m++) begin
      for (int n = 0; n < 5; n++) begin
        pat = 16'hA5C3 ^ 16'((m * 5 + n) * 16'h1357);
        run_frame(n, m[1:0], pat, 1'b0);
        run_frame(n, m[1:0], ~pat ^ 16'h8001, 1'b1);
      end
    end
    run_frame(2, 2'b01, 16'hFFFF, 1'b0);
    run_frame(2, 2'b11, 16'h0000, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule